// File: doc/BRIEF.md
# Dual-Core Hardware Semaphore Bank

This block holds a bank of hardware semaphores that two processor cores share in order to guard common resources. Each semaphore keeps a lock flag, the identity of the bus master that holds it, and an 8-bit process tag. Every access carries a master identity on a sideband, and the bank records that identity as the owner. A core can take a semaphore in one of two ways, and both may be in use on the same bank at once. In the write-then-verify style, the core writes a lock request with its process tag and then reads the register back to confirm it won. In the atomic style, a single read of a separate register takes the semaphore if it is free and returns the resulting state.

Releasing a semaphore can raise an interrupt on either core. Each core has its own enable mask, raw status, masked status and write-one-to-clear register, with one bit per semaphore. Each core also has one interrupt line, which is high while any of that core's masked bits is set.

The register port accepts one access on every cycle in which `req_valid` is high. There is no back-pressure: the bank never stalls a request, and the requester must take a read response in the cycle it appears. A read is answered exactly one cycle later by `rsp_valid` with `rsp_rdata`. A write produces no response.

Top module: `hw_sema_bank`

## Requirements
- R1: After reset every semaphore is free with owner and process tag zero, both cores' enable and raw status registers are zero, and both interrupt lines are low.
- R2: Address = {region[2:0], index[3:0]}. The regions are: 0 lock word, 1 atomic lock, 2 enable, 3 raw status, 4 masked status, 5 clear. In regions 2 to 5, index bit 0 selects the core. A read of any region is answered one cycle later with `rsp_valid`=1. A write gives `rsp_valid`=0. The semaphore word has LOCK at bit 31, the core ID at bits 11:8 and the process tag at bits 7:0, with all other bits 0.
- R3: A region-0 write with bit 31 = 1 to a free semaphore locks it to `req_master`, with the process tag taken from wdata[7:0]. A region-0 read returns the state without changing it.
- R4: A lock write to a semaphore that is already held, by any owner, is ignored. It leaves the lock, core ID and process tag unchanged.
- R5: A region-1 read of a free semaphore locks it to `req_master` with process tag 0 and returns the resulting word. On a held semaphore it returns the current word and changes nothing.
- R6: A region-0 write with bit 31 = 0 frees a held semaphore, clearing its owner and tag, only when both `req_master` and wdata[7:0] match the owner. Any other such write is ignored.
- R7: When a semaphore i is freed, raw status bit i is set for every core whose enable bit i is set. Region 3 reads the raw status.
- R8: Region 4 reads raw status AND enable. `irq_o[c]` is high exactly when core c's masked status is nonzero, starting in the cycle after the register change.
- R9: A region-5 write clears the raw status bits of the selected core where wdata is 1 and leaves the bits where wdata is 0.
- R10: A region-2 write sets the selected core's enable mask from wdata[15:0], and a region-2 read returns it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 7 | {region, index} word address |
| req_wdata | input | 32 | Write data |
| req_master | input | 4 | Bus master ID of the requester |
| rsp_valid | output | 1 | Read response present |
| rsp_rdata | output | 32 | Read response data |
| irq_o | output | 2 | Per-core release interrupt |

## Verification
Every register in the bank changes on the clock edge that accepts an access. A read response therefore appears one cycle after its request, and it reflects the state before that request, or the post-lock state for the atomic read. Each interrupt line follows one cycle after a release, an enable write or a clear write. The bench drives each access at a falling edge and updates a behavioural model of the bank at the same moment. At the next falling edge it compares the response and both interrupt lines with the model, so every result is sampled in the one cycle it is due.

// File: rtl/hsem_pkg.sv
package hsem_pkg;
  localparam int DATA_W   = 32;
  localparam int LOCK_POS = 31;
  localparam int CORE_POS = 8;
  localparam int REGION_W = 3;

  typedef enum logic [REGION_W-1:0] {
    RG_LOCK   = 3'd0,
    RG_ATOMIC = 3'd1,
    RG_ENABLE = 3'd2,
    RG_RAW    = 3'd3,
    RG_MASKED = 3'd4,
    RG_CLEAR  = 3'd5
  } region_e;
endpackage

// File: rtl/hsem_cell.sv
module hsem_cell #(
  parameter int MID_W  = 4,
  parameter int PROC_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_sel,
  input  logic              rd_sel,
  input  logic              wr_lock,
  input  logic [PROC_W-1:0] wr_proc,
  input  logic [MID_W-1:0]  master,
  output logic              locked,
  output logic [MID_W-1:0]  owner,
  output logic [PROC_W-1:0] proc,
  output logic              released
);
  always_comb
    released = wr_sel && !wr_lock && locked && (owner == master) && (proc == wr_proc);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      locked <= 1'b0;
      owner  <= '0;
      proc   <= '0;
    end else if (released) begin
      locked <= 1'b0;
      owner  <= '0;
      proc   <= '0;
    end else if (!locked && wr_sel && wr_lock) begin
      locked <= 1'b1;
      owner  <= master;
      proc   <= wr_proc;
    end else if (!locked && rd_sel) begin
      locked <= 1'b1;
      owner  <= master;
      proc   <= '0;
    end
  end
endmodule

// File: rtl/hsem_irq.sv
module hsem_irq #(
  parameter int NSEM = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en_wr,
  input  logic            clr_wr,
  input  logic [NSEM-1:0] wdata,
  input  logic [NSEM-1:0] rel,
  output logic [NSEM-1:0] en,
  output logic [NSEM-1:0] raw,
  output logic            irq
);
  logic [NSEM-1:0] clr_mask;

  always_comb begin
    clr_mask = clr_wr ? wdata : '0;
    irq      = |(raw & en);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en  <= '0;
      raw <= '0;
    end else begin
      if (en_wr) en <= wdata;
      raw <= (raw & ~clr_mask) | (rel & en);
    end
  end
endmodule

// File: rtl/hw_sema_bank.sv
module hw_sema_bank
  import hsem_pkg::*;
#(
  parameter int NSEM   = 16,
  parameter int MID_W  = 4,
  parameter int PROC_W = 8,
  localparam int IDX_W  = (NSEM > 1) ? $clog2(NSEM) : 1,
  localparam int ADDR_W = IDX_W + REGION_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [MID_W-1:0]  req_master,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [1:0]        irq_o
);
  localparam int NCORE = 2;

  logic [REGION_W-1:0]     region;
  logic [IDX_W-1:0]        idx;
  logic                    csel;
  logic                    idx_ok;
  logic                    do_wr;
  logic                    do_rd;
  logic [NSEM-1:0]         lk_vec;
  logic [NSEM-1:0]         rel_vec;
  logic [NSEM*MID_W-1:0]   own_flat;
  logic [NSEM*PROC_W-1:0]  proc_flat;
  logic [NSEM-1:0]         en_q  [NCORE];
  logic [NSEM-1:0]         raw_q [NCORE];
  logic [DATA_W-1:0]       rd_word;
  logic                    unused_bits;

  assign region      = req_addr[ADDR_W-1 -: REGION_W];
  assign idx         = req_addr[IDX_W-1:0];
  assign csel        = req_addr[0];
  assign idx_ok      = int'(idx) < NSEM;
  assign do_wr       = req_valid && req_write;
  assign do_rd       = req_valid && !req_write;
  assign unused_bits = ^req_wdata;

  for (genvar i = 0; i < NSEM; i++) begin : g_sem
    logic hit;
    assign hit = (idx == IDX_W'(i));
    hsem_cell #(.MID_W(MID_W), .PROC_W(PROC_W)) u_cell (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_sel   (do_wr && hit && region == RG_LOCK),
      .rd_sel   (do_rd && hit && region == RG_ATOMIC),
      .wr_lock  (req_wdata[LOCK_POS]),
      .wr_proc  (req_wdata[PROC_W-1:0]),
      .master   (req_master),
      .locked   (lk_vec[i]),
      .owner    (own_flat[i*MID_W +: MID_W]),
      .proc     (proc_flat[i*PROC_W +: PROC_W]),
      .released (rel_vec[i])
    );
  end

  for (genvar c = 0; c < NCORE; c++) begin : g_core
    logic sel;
    assign sel = (csel == 1'(c));
    hsem_irq #(.NSEM(NSEM)) u_irq (
      .clk    (clk),
      .rst_n  (rst_n),
      .en_wr  (do_wr && sel && region == RG_ENABLE),
      .clr_wr (do_wr && sel && region == RG_CLEAR),
      .wdata  (req_wdata[NSEM-1:0]),
      .rel    (rel_vec),
      .en     (en_q[c]),
      .raw    (raw_q[c]),
      .irq    (irq_o[c])
    );
  end

  always_comb begin
    rd_word = '0;
    case (region)
      RG_LOCK, RG_ATOMIC: begin
        if (idx_ok) begin
          if (region == RG_ATOMIC && !lk_vec[idx]) begin
            rd_word[LOCK_POS]               = 1'b1;
            rd_word[CORE_POS +: MID_W]      = req_master;
          end else begin
            rd_word[LOCK_POS]               = lk_vec[idx];
            rd_word[CORE_POS +: MID_W]      = own_flat[int'(idx)*MID_W +: MID_W];
            rd_word[PROC_W-1:0]             = proc_flat[int'(idx)*PROC_W +: PROC_W];
          end
        end
      end
      RG_ENABLE: rd_word[NSEM-1:0] = en_q[csel];
      RG_RAW:    rd_word[NSEM-1:0] = raw_q[csel];
      RG_MASKED: rd_word[NSEM-1:0] = raw_q[csel] & en_q[csel];
      default:   rd_word = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= do_rd;
      if (do_rd) rsp_rdata <= rd_word;
    end
  end
endmodule

// File: rtl/hsem_checker.sv
module hsem_checker #(
  parameter int NSEM   = 16,
  parameter int MID_W  = 4,
  parameter int ADDR_W = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_write,
  input logic [ADDR_W-1:0] req_addr,
  input logic [31:0]       req_wdata,
  input logic              rsp_valid,
  input logic [31:0]       rsp_rdata,
  input logic [1:0]        irq_o,
  input logic [NSEM-1:0]   lk_vec,
  input logic [NSEM-1:0]   rel_vec,
  input logic [NSEM*MID_W-1:0] own_flat
);
  logic [2:0] rg;
  assign rg = req_addr[ADDR_W-1 -: 3];

  // R2: each read answered next cycle
  a_r2_read_answered: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write) |=> rsp_valid);
  // R2: no response without a read
  a_r2_no_spurious_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && !req_write) |=> !rsp_valid);
  // R5: an atomic read always reports a held semaphore
  a_r5_atomic_reports_held: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write && rg == 3'd1) |=> rsp_rdata[31]);

  for (genvar i = 0; i < NSEM; i++) begin : g_s
    // R4: a held semaphore keeps its owner
    a_r4_owner_kept: assert property (@(posedge clk) disable iff (!rst_n)
      (lk_vec[i] && $past(lk_vec[i])) |-> $stable(own_flat[i*MID_W +: MID_W]));
    // R6: a semaphore only becomes free through a matching release
    a_r6_free_by_release: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(lk_vec[i]) |-> $past(rel_vec[i]));
  end

  for (genvar c = 0; c < 2; c++) begin : g_c
    // R7: an interrupt rises only after a release or an enable write
    a_r7_irq_cause: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_o[c]) |-> $past((|rel_vec) || (req_valid && req_write && rg == 3'd2)));
    // R9: clearing every bit drops the line
    a_r9_clear_all: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_write && rg == 3'd5 && req_addr[0] == 1'(c) &&
       &req_wdata[NSEM-1:0]) |=> !irq_o[c]);
  end
endmodule

bind hw_sema_bank hsem_checker #(.NSEM(NSEM), .MID_W(MID_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
  .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
  .rsp_rdata(rsp_rdata), .irq_o(irq_o), .lk_vec(lk_vec), .rel_vec(rel_vec),
  .own_flat(own_flat)
);

// File: tb/tb_hw_sema_bank.sv
module tb_hw_sema_bank;
  localparam int NS = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [6:0]  req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic [3:0]  req_master = '0;
  logic        rsp_valid;
  logic [31:0] rsp_rdata;
  logic [1:0]  irq_o;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  bit        m_lk [NS];
  int        m_core [NS];
  int        m_proc [NS];
  bit [15:0] m_en [2];
  bit [15:0] m_st [2];
  bit        exp_v = 0;
  bit [31:0] exp_d = '0;
  string     exp_tag = "R2";

  hw_sema_bank dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_master(req_master),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .irq_o(irq_o)
  );

  always #10 clk = ~clk;

  function automatic bit [31:0] mkw(bit l, int c, int p);
    bit [31:0] w = '0;
    w[31] = l;
    w[11:8] = c[3:0];
    w[7:0] = p[7:0];
    return w;
  endfunction

  task automatic chk(string tag, bit [31:0] act, bit [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic compare_outputs();
    chk({exp_tag, " rsp_valid"}, 32'(rsp_valid), 32'(exp_v));
    if (exp_v) chk({exp_tag, " rsp_rdata"}, rsp_rdata, exp_d);
    for (int c = 0; c < 2; c++)
      chk("R8 irq", 32'(irq_o[c]), 32'(|(m_st[c] & m_en[c])));
  endtask

  task automatic model_apply(bit wr, int rg, int ix, bit [31:0] wd, int mst);
    int c = ix % 2;
    exp_v = !wr;
    exp_d = '0;
    case (rg)
      0: if (wr) begin
           if (wd[31]) begin
             if (!m_lk[ix]) begin m_lk[ix] = 1; m_core[ix] = mst; m_proc[ix] = int'(wd[7:0]); end
           end else if (m_lk[ix] && m_core[ix] == mst && m_proc[ix] == int'(wd[7:0])) begin
             m_lk[ix] = 0; m_core[ix] = 0; m_proc[ix] = 0;
             for (int k = 0; k < 2; k++) if (m_en[k][ix]) m_st[k][ix] = 1;
           end
         end else exp_d = mkw(m_lk[ix], m_core[ix], m_proc[ix]);
      1: if (!wr) begin
           if (!m_lk[ix]) begin m_lk[ix] = 1; m_core[ix] = mst; m_proc[ix] = 0; end
           exp_d = mkw(m_lk[ix], m_core[ix], m_proc[ix]);
         end
      2: if (wr) m_en[c] = wd[15:0]; else exp_d = {16'h0, m_en[c]};
      3: if (!wr) exp_d = {16'h0, m_st[c]};
      4: if (!wr) exp_d = {16'h0, m_st[c] & m_en[c]};
      5: if (wr) m_st[c] = m_st[c] & ~wd[15:0];
      default: exp_d = '0;
    endcase
  endtask

  task automatic xfer(bit wr, int rg, int ix, bit [31:0] wd, int mst, string tag);
    @(negedge clk);
    compare_outputs();
    req_valid = 1'b1;
    req_write = wr;
    req_addr = {rg[2:0], ix[3:0]};
    req_wdata = wd;
    req_master = mst[3:0];
    model_apply(wr, rg, ix, wd, mst);
    exp_tag = tag;
  endtask

  task automatic idle();
    @(negedge clk);
    compare_outputs();
    req_valid = 1'b0;
    exp_v = 0;
    exp_tag = "R2";
  endtask

  function automatic string tag_of(int rg);
    case (rg)
      0: return "R3";
      1: return "R5";
      2: return "R10";
      3: return "R7";
      4: return "R8";
      default: return "R9";
    endcase
  endfunction

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : stim
    for (int i = 0; i < NS; i++) begin m_lk[i] = 0; m_core[i] = 0; m_proc[i] = 0; end
    for (int c = 0; c < 2; c++) begin m_en[c] = '0; m_st[c] = '0; end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    chk("R1 irq after reset", 32'(irq_o), 32'h0);
    // R1: reset state
    for (int i = 0; i < NS; i++) xfer(0, 0, i, 0, 1, "R1");
    for (int c = 0; c < 2; c++) begin
      xfer(0, 2, c, 0, 1, "R1");
      xfer(0, 3, c, 0, 1, "R1");
    end
    // R10: enable masks
    xfer(1, 2, 0, 32'h0F0F, 1, "R10");
    xfer(1, 2, 1, 32'h00FF, 2, "R10");
    xfer(0, 2, 0, 0, 1, "R10");
    xfer(0, 2, 1, 0, 2, "R10");
    // R3: two-step lock
    xfer(1, 0, 3, 32'h8000_0021, 1, "R3");
    xfer(0, 0, 3, 0, 2, "R3");
    // R4: lock attempts on a held semaphore
    xfer(1, 0, 3, 32'h8000_0055, 2, "R4");
    xfer(0, 0, 3, 0, 1, "R4");
    xfer(1, 0, 3, 32'h8000_0099, 1, "R4");
    xfer(0, 0, 3, 0, 1, "R4");
    // R5: one-step lock
    xfer(0, 1, 5, 0, 2, "R5");
    xfer(0, 1, 5, 0, 1, "R5");
    xfer(0, 1, 3, 0, 2, "R5");
    xfer(0, 0, 5, 0, 1, "R5");
    // R6: unlock ownership checks
    xfer(1, 0, 3, 32'h0000_0021, 2, "R6");
    xfer(0, 0, 3, 0, 1, "R6");
    xfer(1, 0, 3, 32'h0000_0022, 1, "R6");
    xfer(0, 0, 3, 0, 1, "R6");
    xfer(1, 0, 7, 32'h0000_0000, 1, "R6");
    xfer(1, 0, 3, 32'h0000_0021, 1, "R6");
    xfer(0, 0, 3, 0, 1, "R6");
    // R7: raw status after release
    xfer(0, 3, 0, 0, 1, "R7");
    xfer(0, 3, 1, 0, 1, "R7");
    xfer(1, 0, 5, 32'h0000_0000, 2, "R7");
    xfer(1, 0, 9, 32'h8000_0004, 1, "R7");
    xfer(1, 0, 9, 32'h0000_0004, 1, "R7");
    xfer(0, 3, 0, 0, 1, "R7");
    xfer(0, 3, 1, 0, 2, "R7");
    xfer(0, 4, 0, 0, 1, "R8");
    xfer(0, 4, 1, 0, 2, "R8");
    // R9: write-one-to-clear
    xfer(1, 5, 0, 32'h0008, 1, "R9");
    xfer(0, 3, 0, 0, 1, "R9");
    xfer(1, 5, 1, 32'h0000, 1, "R9");
    xfer(0, 3, 1, 0, 1, "R9");
    xfer(1, 5, 0, 32'h0200, 1, "R9");
    xfer(0, 3, 0, 0, 1, "R9");
    // R8: masking by enable
    xfer(1, 2, 1, 32'h0000, 2, "R8");
    xfer(0, 4, 1, 0, 2, "R8");
    xfer(0, 3, 1, 0, 2, "R8");
    xfer(1, 2, 1, 32'h0020, 2, "R8");
    xfer(0, 4, 1, 0, 2, "R8");
    xfer(1, 5, 1, 32'hFFFF, 2, "R9");
    idle();
    // mixed traffic
    for (int n = 0; n < 400; n++) begin
      int rg = int'($urandom_range(0, 5));
      int ix = int'($urandom_range(0, 3));
      int mst = int'($urandom_range(1, 2));
      bit wr = (rg == 1 || rg == 3 || rg == 4) ? 1'b0 : 1'($urandom_range(0, 1));
      bit [31:0] wd = {1'($urandom_range(0, 1)), 15'h0, 16'($urandom_range(0, 3))};
      if (rg == 2 || rg == 5) wd = 32'($urandom_range(0, 65535));
      if (n % 7 == 0) idle();
      else xfer(wr, rg, ix, wd, mst, tag_of(rg));
    end
    idle();
    idle();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule